// File: doc/BRIEF.md
# Cascadable Signed Multiplier Slice

This block multiplies two signed 18-bit operands and returns the full 36-bit signed product. The first operand always comes from its own port. The second operand comes from one of two sources, chosen at compile time: the slice's own direct operand port, or a cascade input that a neighbouring slice drives. Each operand can be held in a register before the multiplier, and the product can be held in a register after it. Parameters turn each of these registers on or off. When every register is on, the slice has two cycles of latency. When every register is off, it is purely combinational.

Whatever second operand actually reaches the multiplier is also driven on a cascade output. If the second-operand register is on, that value is taken after the register. Connecting this output to a neighbour's cascade input lets a row of slices share one B value. If the neighbours also register it, the value moves one stage per cycle down the row, which suits filter taps.

Each enabled register has its own clock enable and its own synchronous clear. A chip-wide asynchronous active-low reset also clears every enabled register.

Top module: `mul_slice`

## Requirements
- R1: `prod` is the two's-complement product of the signed operands that reach the multiplier, at full 36-bit precision with no rounding or saturation.
- R2: With `B_SRC = SRC_DIRECT`, the second operand is `b_in`. With `B_SRC = SRC_CASCADE`, it is `casc_in`, and `b_in` has no effect on any output.
- R3: `casc_out` always equals the second operand applied to the multiplier. That is the selected source when `B_REG = 0`, and the B register contents when `B_REG = 1`.
- R4: The latency from an operand port to `prod` equals the number of enabled registers on that path: the operand register plus `P_REG`, which is 0, 1 or 2 cycles.
- R5: An enabled register loads on a rising clock edge only while its enable (`ce_a`, `ce_b` or `ce_p`) is 1. Otherwise it holds its value.
- R6: An enabled register whose clear (`clr_a`, `clr_b` or `clr_p`) is 1 at a rising edge becomes zero, whatever its enable is.
- R7: A register disabled by its parameter is a plain wire, and its enable and clear have no effect on `prod` or `casc_out`.
- R8: While `rst_n` is 0, every enabled register is zero, and `rst_n` acts without a clock edge.
- R9: When slices are chained output-to-input, a slice with `B_REG = 1` presents to its multiplier, one cycle later, the value its neighbour showed on `casc_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | 18 | First operand, signed |
| b_in | input | 18 | Direct second operand, signed |
| casc_in | input | 18 | Cascade second operand from a neighbouring slice |
| ce_a | input | 1 | Load enable of the A register |
| clr_a | input | 1 | Synchronous clear of the A register |
| ce_b | input | 1 | Load enable of the B register |
| clr_b | input | 1 | Synchronous clear of the B register |
| ce_p | input | 1 | Load enable of the product register |
| clr_p | input | 1 | Synchronous clear of the product register |
| casc_out | output | 18 | Second operand as applied to the multiplier |
| prod | output | 36 | Signed product |

## Verification
Two events can fall on the same rising edge: a register's clear and its load enable, and a new operand entering the B register while the product register captures the operands from the previous cycle. The bench raises the clear and the enable of the B register and of the product register together, and expects zero. In the same cycle it expects the product register to hold the product of the operands that were stored before the edge. Four slices in two chained pairs cover every combination of operand source and B register. Corner values and pseudo-random operands are swept through all four slices, and each output is compared with an arithmetic product delayed by the expected number of cycles.

// File: rtl/mul_slice_pkg.sv
package mul_slice_pkg;
  // Source of the second multiplier operand.
  typedef enum logic {
    SRC_DIRECT  = 1'b0,
    SRC_CASCADE = 1'b1
  } b_src_e;
endpackage

// File: rtl/mul_slice_optreg.sv
// Optional pipeline stage: a register with load enable and synchronous
// clear when EN is set, a straight wire otherwise.
module mul_slice_optreg #(
  parameter int W  = 18,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (EN) begin : g_reg
      logic [W-1:0] q_r;
      logic [W-1:0] q_nxt;

      // clear outranks the load enable
      always_comb begin
        q_nxt = q_r;
        if (clr) begin
          q_nxt = '0;
        end else if (ce) begin
          q_nxt = d;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_r <= '0;
        end else begin
          q_r <= q_nxt;
        end
      end

      assign q = q_r;
    end else begin : g_wire
      logic unused_ctl;
      assign unused_ctl = ^{clk, rst_n, ce, clr};
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/mul_slice_bsel.sv
// Compile-time choice of the second operand source.
module mul_slice_bsel
  import mul_slice_pkg::*;
#(
  parameter int     W   = 18,
  parameter b_src_e SRC = SRC_DIRECT
) (
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] casc_in,
  output logic [W-1:0] b_sel
);

  generate
    if (SRC == SRC_CASCADE) begin : g_cascade
      logic unused_direct;
      assign unused_direct = ^b_in;
      assign b_sel = casc_in;
    end else begin : g_direct
      logic unused_cascade;
      assign unused_cascade = ^casc_in;
      assign b_sel = b_in;
    end
  endgenerate

endmodule

// File: rtl/mul_slice_mult.sv
// Full-precision two's-complement multiplier.
module mul_slice_mult #(
  parameter int AW = 18,
  parameter int BW = 18
) (
  input  logic [AW-1:0]    a,
  input  logic [BW-1:0]    b,
  output logic [AW+BW-1:0] p
);

  localparam int PW = AW + BW;

  logic signed [PW-1:0] a_ext;
  logic signed [PW-1:0] b_ext;

  assign a_ext = PW'($signed(a));
  assign b_ext = PW'($signed(b));
  assign p     = a_ext * b_ext;

endmodule

// File: rtl/mul_slice.sv
// Signed multiplier slice with optional A, B and product registers and a
// shareable second operand.
module mul_slice
  import mul_slice_pkg::*;
#(
  parameter int     A_W   = 18,
  parameter int     B_W   = 18,
  parameter bit     A_REG = 1'b1,
  parameter bit     B_REG = 1'b1,
  parameter bit     P_REG = 1'b1,
  parameter b_src_e B_SRC = SRC_DIRECT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [A_W-1:0]     a_in,
  input  logic [B_W-1:0]     b_in,
  input  logic [B_W-1:0]     casc_in,
  input  logic               ce_a,
  input  logic               clr_a,
  input  logic               ce_b,
  input  logic               clr_b,
  input  logic               ce_p,
  input  logic               clr_p,
  output logic [B_W-1:0]     casc_out,
  output logic [A_W+B_W-1:0] prod
);

  localparam int P_W = A_W + B_W;

  logic [B_W-1:0] b_sel;
  logic [A_W-1:0] a_op;
  logic [B_W-1:0] b_op;
  logic [P_W-1:0] p_raw;

  mul_slice_bsel #(.W(B_W), .SRC(B_SRC)) u_bsel (
    .b_in    (b_in),
    .casc_in (casc_in),
    .b_sel   (b_sel)
  );

  mul_slice_optreg #(.W(A_W), .EN(A_REG)) u_areg (
    .clk   (clk),
    .rst_n (rst_n),
    .ce    (ce_a),
    .clr   (clr_a),
    .d     (a_in),
    .q     (a_op)
  );

  mul_slice_optreg #(.W(B_W), .EN(B_REG)) u_breg (
    .clk   (clk),
    .rst_n (rst_n),
    .ce    (ce_b),
    .clr   (clr_b),
    .d     (b_sel),
    .q     (b_op)
  );

  mul_slice_mult #(.AW(A_W), .BW(B_W)) u_mult (
    .a (a_op),
    .b (b_op),
    .p (p_raw)
  );

  mul_slice_optreg #(.W(P_W), .EN(P_REG)) u_preg (
    .clk   (clk),
    .rst_n (rst_n),
    .ce    (ce_p),
    .clr   (clr_p),
    .d     (p_raw),
    .q     (prod)
  );

  // the operand really used, taken after the optional B stage
  assign casc_out = b_op;

endmodule

// File: rtl/mul_slice_chk.sv
// Port-level properties of the multiplier slice.
module mul_slice_chk
  import mul_slice_pkg::*;
#(
  parameter int     A_W   = 18,
  parameter int     B_W   = 18,
  parameter bit     A_REG = 1'b1,
  parameter bit     B_REG = 1'b1,
  parameter bit     P_REG = 1'b1,
  parameter b_src_e B_SRC = SRC_DIRECT
) (
  input logic               clk,
  input logic               rst_n,
  input logic [A_W-1:0]     a_in,
  input logic [B_W-1:0]     b_in,
  input logic [B_W-1:0]     casc_in,
  input logic               ce_a,
  input logic               clr_a,
  input logic               ce_b,
  input logic               clr_b,
  input logic               ce_p,
  input logic               clr_p,
  input logic [B_W-1:0]     casc_out,
  input logic [A_W+B_W-1:0] prod
);

  localparam int P_W = A_W + B_W;

  logic [B_W-1:0] src_b;
  assign src_b = (B_SRC == SRC_CASCADE) ? casc_in : b_in;

  logic unused_chk;
  assign unused_chk = ^{a_in, ce_a, clr_a, ce_p, clr_p, ce_b, clr_b};

  generate
    if (B_REG) begin : g_b_reg
      AST_B_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_b |=> (casc_out == '0)); // R6
      AST_B_LOADS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_b && !clr_b) |=> (casc_out == $past(src_b))); // R3
      AST_B_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_b && !clr_b) |=> $stable(casc_out)); // R5
    end else begin : g_b_wire
      AST_B_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        casc_out == src_b); // R3
    end

    if (P_REG) begin : g_p_reg
      AST_P_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_p |=> (prod == '0)); // R6
      AST_P_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_p && !clr_p) |=> $stable(prod)); // R5
    end

    if (!A_REG && !B_REG && !P_REG) begin : g_comb
      logic signed [P_W-1:0] ref_p;
      assign ref_p = P_W'($signed(a_in)) * P_W'($signed(src_b));
      AST_COMB_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        prod == ref_p); // R1
    end
  endgenerate

endmodule

bind mul_slice mul_slice_chk #(
  .A_W   (A_W),
  .B_W   (B_W),
  .A_REG (A_REG),
  .B_REG (B_REG),
  .P_REG (P_REG),
  .B_SRC (B_SRC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .a_in     (a_in),
  .b_in     (b_in),
  .casc_in  (casc_in),
  .ce_a     (ce_a),
  .clr_a    (clr_a),
  .ce_b     (ce_b),
  .clr_b    (clr_b),
  .ce_p     (ce_p),
  .clr_p    (clr_p),
  .casc_out (casc_out),
  .prod     (prod)
);

// File: tb/mul_slice_bench.sv
`timescale 1ns/1ps
module mul_slice_bench;
  import mul_slice_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic ce_a, ce_b, ce_p, clr_a, clr_b, clr_p;
  logic signed [17:0] a, a2, b, b_junk;
  logic signed [17:0] pa, pb, pa2;

  logic [17:0] c0, c1, c2, c3;
  logic [35:0] p0, p1, p2, p3;

  int total = 0;
  int bad   = 0;

  // all registers, direct source: head of the registered chain
  mul_slice #(.A_REG(1), .B_REG(1), .P_REG(1), .B_SRC(SRC_DIRECT)) u_mul_slice (
    .clk(clk), .rst_n(rst_n), .a_in(a), .b_in(b), .casc_in(b_junk),
    .ce_a(ce_a), .clr_a(clr_a), .ce_b(ce_b), .clr_b(clr_b),
    .ce_p(ce_p), .clr_p(clr_p), .casc_out(c0), .prod(p0));

  // cascade source, B registered, A and P as wires
  mul_slice #(.A_REG(0), .B_REG(1), .P_REG(0), .B_SRC(SRC_CASCADE)) u_chain (
    .clk(clk), .rst_n(rst_n), .a_in(a2), .b_in(b_junk), .casc_in(c0),
    .ce_a(ce_a), .clr_a(clr_a), .ce_b(ce_b), .clr_b(clr_b),
    .ce_p(ce_p), .clr_p(clr_p), .casc_out(c1), .prod(p1));

  // fully combinational, direct source
  mul_slice #(.A_REG(0), .B_REG(0), .P_REG(0), .B_SRC(SRC_DIRECT)) u_comb0 (
    .clk(clk), .rst_n(rst_n), .a_in(a), .b_in(b), .casc_in(b_junk),
    .ce_a(ce_a), .clr_a(clr_a), .ce_b(ce_b), .clr_b(clr_b),
    .ce_p(ce_p), .clr_p(clr_p), .casc_out(c2), .prod(p2));

  // cascade source, B unregistered, A and P registered
  mul_slice #(.A_REG(1), .B_REG(0), .P_REG(1), .B_SRC(SRC_CASCADE)) u_comb1 (
    .clk(clk), .rst_n(rst_n), .a_in(a2), .b_in(b_junk), .casc_in(c2),
    .ce_a(ce_a), .clr_a(clr_a), .ce_b(ce_b), .clr_b(clr_b),
    .ce_p(ce_p), .clr_p(clr_p), .casc_out(c3), .prod(p3));

  function automatic logic [35:0] mulx(input logic signed [17:0] x,
                                       input logic signed [17:0] y);
    longint r;
    r = longint'(x) * longint'(y);
    return r[35:0];
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // drive one operand set, let one rising edge pass, return at the falling edge
  task automatic step(input logic [17:0] na, input logic [17:0] nb);
    a      = na;
    b      = nb;
    a2     = ~na;
    b_junk = nb ^ 18'h15A5A;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_sweep();
    chk("R4 R1 two-stage product",       p0, mulx(pa, pb));
    chk("R3 registered cascade out",     {18'd0, c0}, {18'd0, b});
    chk("R9 chained operand one later",  {18'd0, c1}, {18'd0, pb});
    chk("R2 cascade source, b_in unused", p1, mulx(a2, pb));
    chk("R3 unregistered cascade out",   {18'd0, c2}, {18'd0, b});
    chk("R4 R1 zero-latency product",    p2, mulx(a, b));
    chk("R3 cascade passthrough",        {18'd0, c3}, {18'd0, b});
    chk("R4 mixed-latency product",      p3, mulx(pa2, b));
    pa  = a;
    pb  = b;
    pa2 = a2;
  endtask

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic signed [17:0] corner [8];
    logic [31:0] lf;
    logic [17:0] x1, y1, x2, y2;
    corner = '{18'sh00000, 18'sh00001, 18'sh3FFFF, 18'sh00002,
               18'sh3FFFE, 18'sh1FFFF, 18'sh20000, 18'sh0AAAA};
    rst_n = 1'b0;
    ce_a = 1'b1; ce_b = 1'b1; ce_p = 1'b1;
    clr_a = 1'b0; clr_b = 1'b0; clr_p = 1'b0;
    a = 18'sd5; a2 = 18'sd9; b = 18'sd7; b_junk = 18'sd3;
    pa = '0; pb = '0; pa2 = '0;
    repeat (3) @(negedge clk);

    // R8: the asynchronous reset keeps every enabled register at zero
    chk("R8 reset product register", p0, 36'd0);
    chk("R8 reset B register",       {18'd0, c0}, 36'd0);
    chk("R8 reset chained B",        {18'd0, c1}, 36'd0);
    chk("R8 reset mixed product",    p3, 36'd0);
    rst_n = 1'b1;

    // corner-value sweep through all four slices
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        step(corner[i], corner[j]);
        check_sweep();
      end
    end

    // pseudo-random sweep
    lf = 32'hACE1_1234;
    for (int k = 0; k < 300; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      step(lf[17:0], lf[31:14]);
      check_sweep();
    end

    // enable and clear behaviour of the fully registered slice
    x1 = 18'h2F00D; y1 = 18'h01234; x2 = 18'h1ABCD; y2 = 18'h3C001;
    step(x1, y1);
    step(x1, y1);
    chk("R5 R1 product after two loads", p0, mulx(x1, y1));

    ce_a = 1'b0; ce_b = 1'b0;
    step(x2, y2);
    chk("R5 B register holds with enable low", {18'd0, c0}, {18'd0, y1});
    chk("R5 product built from held operands", p0, mulx(x1, y1));
    chk("R7 wire-only slice ignores enables", p2, mulx(x2, y2));

    ce_a = 1'b1; ce_b = 1'b1; ce_p = 1'b0;
    step(x2, y2);
    chk("R5 B register loads with enable high", {18'd0, c0}, {18'd0, y2});
    chk("R5 product register holds",          p0, mulx(x1, y1));

    // clear and enable on the same edge; product captures the stored operands
    ce_p = 1'b1; clr_b = 1'b1;
    step(x2, y2);
    chk("R6 B clear beats enable", {18'd0, c0}, 36'd0);
    chk("R5 product captured alongside B clear", p0, mulx(x2, y2));

    clr_b = 1'b0; clr_p = 1'b1;
    step(x2, y2);
    chk("R6 product clear beats enable", p0, 36'd0);
    chk("R5 B reloads after clear",      {18'd0, c0}, {18'd0, y2});
    chk("R7 wire-only slice ignores clears", p2, mulx(x2, y2));
    chk("R7 wire-only cascade ignores clears", {18'd0, c2}, {18'd0, y2});

    clr_p = 1'b0; clr_a = 1'b1; ce_a = 1'b0;
    step(x2, y2);
    chk("R5 product of A before its clear", p0, mulx(x2, y2));
    clr_a = 1'b0;
    step(x2, y2);
    chk("R6 A clear without enable", p0, 36'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule